// File: doc/BRIEF.md
# Segment Base-Limit Translator

This block turns a two-part logical address, a segment number plus an offset inside that segment, into a physical address. A small register table holds one descriptor per segment. Each descriptor has a physical base, a length limit, a present flag and three permission bits for read, write and execute. Software loads descriptors through a write port. The lookup side takes one request per cycle, tagged with its access kind. One clock later it returns either the translated address or a fault code.

The checks run in a fixed order. An absent segment is reported first. Next comes an offset that falls outside the segment. A permission mismatch is reported last. Only the first failure is reported, and a faulting response always carries a zero address. Two descriptors may point at the same base and limit, which lets two segment numbers share one physical region. Table depth, segment-number width, offset width and base width are parameters.

Top module: `seg_xlate`

## Requirements
- R1: After a synchronous active-low reset, `rsp_valid` is 0, `rsp_paddr` and `rsp_fault` are 0, and every descriptor is absent. A lookup made after reset therefore reports fault code 1.
- R2: A request sampled with `req_valid` high produces `rsp_valid` high on the next clock edge. In every cycle without a response, `rsp_valid`, `rsp_paddr` and `rsp_fault` are all 0.
- R3: A lookup that passes every check reports fault code 0 and `rsp_paddr` = base + offset. The sum is formed at BASE_W+1 bits, so it never wraps.
- R4: An offset that is equal to or greater than the segment limit reports fault code 2. An offset of exactly limit-1 passes this check.
- R5: Fault code 1 is reported in two cases: the segment number is NSEG or above, or the addressed descriptor's present flag is clear.
- R6: The access kinds are encoded as 0 = read, 1 = write, 2 = execute and 3 = reserved. The permission bits are bit0 = read, bit1 = write and bit2 = execute. Fault code 3 is reported when the bit for the requested kind is clear. A reserved kind always reports fault code 3.
- R7: When several checks fail, the code reported follows this priority: 1 over 2 over 3.
- R8: Whenever the fault code is nonzero, `rsp_paddr` is 0.
- R9: A descriptor write is seen by lookups sampled on the following edge. A lookup sampled on the same edge as the write sees the old descriptor.
- R10: A write whose index is NSEG or above changes no descriptor.
- R11: Two segment numbers loaded with the same base and limit translate the same offset to the same physical address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Descriptor write strobe |
| wr_idx | input | SEG_W | Descriptor index to write |
| wr_base | input | BASE_W | Physical base to store |
| wr_limit | input | OFF_W+1 | Segment length to store |
| wr_present | input | 1 | Present flag to store |
| wr_perm | input | 3 | Permissions to store (bit0 read, bit1 write, bit2 execute) |
| req_valid | input | 1 | Lookup request strobe |
| req_seg | input | SEG_W | Segment number |
| req_off | input | OFF_W | Offset inside the segment |
| req_acc | input | 2 | Access kind (0 read, 1 write, 2 execute, 3 reserved) |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_paddr | output | BASE_W+1 | Physical address, 0 when faulting |
| rsp_fault | output | 2 | 0 none, 1 absent segment, 2 limit, 3 permission |

## Verification
A corrupted descriptor, or a write that lands on the wrong index, has no effect at the ports until that segment is looked up. From then on it shows as a wrong address or a wrong fault code in the very next response. The bench therefore reads back every loaded segment on the cycle right after a write, and also on the same cycle as a write. A wrong check order or a stale response register also shows within one cycle, because a behavioural model predicts every response cycle and every idle cycle.

// File: rtl/seg_pkg.sv
// Package: shared encodings for the segment translator.
// Assumes: access kinds and fault codes are 2 bits wide.
package seg_pkg;
    typedef enum logic [1:0] {
        ACC_RD  = 2'd0,
        ACC_WR  = 2'd1,
        ACC_EX  = 2'd2,
        ACC_RSV = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_ABS   = 2'd1,
        FLT_LIMIT = 2'd2,
        FLT_PERM  = 2'd3
    } fault_e;

    localparam int PERM_RD_BIT = 0;
    localparam int PERM_WR_BIT = 1;
    localparam int PERM_EX_BIT = 2;
    localparam int PERM_W      = 3;
endpackage

// File: rtl/seg_table.sv
// Module: register-file descriptor table with one write port and one
// combinational read port.
// Assumes: rd_hit is low for indices at or above NSEG. A write is stored
// at the clock edge, so a read in the same cycle still sees the old entry.
module seg_table #(
    parameter int NSEG   = 8,
    parameter int SEG_W  = 4,
    parameter int OFF_W  = 12,
    parameter int BASE_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [SEG_W-1:0]           wr_idx,
    input  logic [BASE_W-1:0]          wr_base,
    input  logic [OFF_W:0]             wr_limit,
    input  logic                       wr_present,
    input  logic [seg_pkg::PERM_W-1:0] wr_perm,
    input  logic [SEG_W-1:0]           rd_idx,
    output logic                       rd_hit,
    output logic [BASE_W-1:0]          rd_base,
    output logic [OFF_W:0]             rd_limit,
    output logic [seg_pkg::PERM_W-1:0] rd_perm
);
    localparam int IDX_W = (NSEG > 1) ? $clog2(NSEG) : 1;

    logic [BASE_W-1:0]          base_q [NSEG];
    logic [OFF_W:0]             lim_q  [NSEG];
    logic [seg_pkg::PERM_W-1:0] perm_q [NSEG];
    logic [NSEG-1:0]            pres_q;
    logic [NSEG-1:0]            wr_sel;

    // Per-entry write decode; an out-of-range index selects no entry.
    for (genvar gi = 0; gi < NSEG; gi++) begin : g_sel
        assign wr_sel[gi] = wr_en && ({1'b0, wr_idx} == (SEG_W+1)'(gi));
    end

    // Descriptor storage: cleared by reset, loaded by the selected strobe.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NSEG; i++) begin
            if (!rst_n) begin
                base_q[i] <= '0;
                lim_q[i]  <= '0;
                perm_q[i] <= '0;
                pres_q[i] <= 1'b0;
            end else if (wr_sel[i]) begin
                base_q[i] <= wr_base;
                lim_q[i]  <= wr_limit;
                perm_q[i] <= wr_perm;
                pres_q[i] <= wr_present;
            end
        end
    end

    logic             in_range;
    logic [IDX_W-1:0] ridx;

    // Read mux; a miss returns zero fields.
    always_comb begin
        in_range = ({1'b0, rd_idx} < (SEG_W+1)'(NSEG));
        ridx     = IDX_W'(rd_idx);
        rd_hit   = 1'b0;
        rd_base  = '0;
        rd_limit = '0;
        rd_perm  = '0;
        if (in_range) begin
            rd_hit   = pres_q[ridx];
            rd_base  = base_q[ridx];
            rd_limit = lim_q[ridx];
            rd_perm  = perm_q[ridx];
        end
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (pres_q == '0));

    // R10
    no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ({1'b0, wr_idx} >= (SEG_W+1)'(NSEG))) |=> $stable(pres_q));
endmodule

// File: rtl/seg_check.sv
// Module: ordered fault evaluation and address sum, purely combinational.
// Assumes: hit already folds the range and present checks. Priority is
// absent, then limit, then permission. A fault forces the address to zero.
module seg_check #(
    parameter int OFF_W  = 12,
    parameter int BASE_W = 16
) (
    input  logic                       hit,
    input  logic [BASE_W-1:0]          base,
    input  logic [OFF_W:0]             limit,
    input  logic [seg_pkg::PERM_W-1:0] perm,
    input  logic [OFF_W-1:0]           off,
    input  logic [1:0]                 acc,
    output logic [1:0]                 fault,
    output logic [BASE_W:0]            paddr
);
    import seg_pkg::*;

    logic allowed;

    // Permission selection by access kind; the reserved kind is never allowed.
    always_comb begin
        case (acc_e'(acc))
            ACC_RD:  allowed = perm[PERM_RD_BIT];
            ACC_WR:  allowed = perm[PERM_WR_BIT];
            ACC_EX:  allowed = perm[PERM_EX_BIT];
            default: allowed = 1'b0;
        endcase
    end

    // Ordered checks, then the sum for a clean access.
    always_comb begin
        paddr = '0;
        if (!hit)                      fault = FLT_ABS;
        else if ({1'b0, off} >= limit) fault = FLT_LIMIT;
        else if (!allowed)             fault = FLT_PERM;
        else begin
            fault = FLT_NONE;
            paddr = {1'b0, base} + (BASE_W+1)'(off);
        end
    end
endmodule

// File: rtl/seg_xlate.sv
// Module: top of the segment translator. It joins the table to the checker
// and registers the response.
// Assumes: one request per cycle. The response appears one edge later and
// is all zeros in cycles without a response.
module seg_xlate #(
    parameter int NSEG   = 8,
    parameter int SEG_W  = 4,
    parameter int OFF_W  = 12,
    parameter int BASE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEG_W-1:0]  wr_idx,
    input  logic [BASE_W-1:0] wr_base,
    input  logic [OFF_W:0]    wr_limit,
    input  logic              wr_present,
    input  logic [2:0]        wr_perm,
    input  logic              req_valid,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [1:0]        req_acc,
    output logic              rsp_valid,
    output logic [BASE_W:0]   rsp_paddr,
    output logic [1:0]        rsp_fault
);
    logic              t_hit;
    logic [BASE_W-1:0] t_base;
    logic [OFF_W:0]    t_limit;
    logic [2:0]        t_perm;
    logic [1:0]        c_fault;
    logic [BASE_W:0]   c_paddr;

    seg_table #(.NSEG(NSEG), .SEG_W(SEG_W), .OFF_W(OFF_W), .BASE_W(BASE_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_base(wr_base), .wr_limit(wr_limit),
        .wr_present(wr_present), .wr_perm(wr_perm),
        .rd_idx(req_seg), .rd_hit(t_hit), .rd_base(t_base),
        .rd_limit(t_limit), .rd_perm(t_perm)
    );

    seg_check #(.OFF_W(OFF_W), .BASE_W(BASE_W)) u_check (
        .hit(t_hit), .base(t_base), .limit(t_limit), .perm(t_perm),
        .off(req_off), .acc(req_acc), .fault(c_fault), .paddr(c_paddr)
    );

    // Response register: captures the checker result or clears to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_paddr <= '0;
            rsp_fault <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_paddr <= req_valid ? c_paddr : '0;
            rsp_fault <= req_valid ? c_fault : '0;
        end
    end

    // R2
    one_cycle_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R2
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_paddr == '0 && rsp_fault == 2'd0));

    // R8
    fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fault != 2'd0) |-> (rsp_paddr == '0));

    // R5
    out_of_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ({1'b0, req_seg} >= (SEG_W+1)'(NSEG))) |=> (rsp_fault == 2'd1));
endmodule

// File: tb/tb_seg_xlate.sv
module tb_seg_xlate;
    localparam int NSEG = 8, SEG_W = 4, OFF_W = 12, BASE_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, wr_present = 1'b0, req_valid = 1'b0;
    logic [SEG_W-1:0] wr_idx = '0, req_seg = '0;
    logic [BASE_W-1:0] wr_base = '0;
    logic [OFF_W:0] wr_limit = '0;
    logic [2:0] wr_perm = '0;
    logic [OFF_W-1:0] req_off = '0;
    logic [1:0] req_acc = '0;
    logic rsp_valid;
    logic [BASE_W:0] rsp_paddr;
    logic [1:0] rsp_fault;

    int checks = 0, failures = 0;

    always #10 clk = ~clk;

    seg_xlate #(.NSEG(NSEG), .SEG_W(SEG_W), .OFF_W(OFF_W), .BASE_W(BASE_W)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_base(wr_base),
        .wr_limit(wr_limit), .wr_present(wr_present), .wr_perm(wr_perm),
        .req_valid(req_valid), .req_seg(req_seg), .req_off(req_off), .req_acc(req_acc),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault));

    // Behavioural reference model
    int m_base [NSEG];
    int m_lim  [NSEG];
    int m_perm [NSEG];
    bit m_pres [NSEG];
    bit e_v = 0;
    int e_pa = 0, e_f = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSEG; i++) begin
                m_pres[i] = 0; m_base[i] = 0; m_lim[i] = 0; m_perm[i] = 0;
            end
            e_v = 0; e_pa = 0; e_f = 0;
        end else begin
            int s, o, a;
            s = int'(req_seg); o = int'(req_off); a = int'(req_acc);
            e_v = req_valid; e_pa = 0; e_f = 0;
            if (req_valid) begin
                if (s >= NSEG || !m_pres[s]) e_f = 1;
                else if (o >= m_lim[s]) e_f = 2;
                else if (a == 3 || ((m_perm[s] >> a) & 1) == 0) e_f = 3;
                else e_pa = m_base[s] + o;
            end
            if (wr_en && int'(wr_idx) < NSEG) begin
                m_base[wr_idx] = int'(wr_base);
                m_lim[wr_idx]  = int'(wr_limit);
                m_perm[wr_idx] = int'(wr_perm);
                m_pres[wr_idx] = wr_present;
            end
        end
    end

    // Per-cycle comparison against the model, away from the rising edge
    always @(negedge clk) begin
        if (rst_n) begin
            string tag;
            checks++;
            if (!e_v) tag = "R2";
            else case (e_f)
                0: tag = "R3"; 1: tag = "R5"; 2: tag = "R4"; default: tag = "R6";
            endcase
            if (rsp_valid !== e_v || rsp_paddr !== (BASE_W+1)'(e_pa) || rsp_fault !== 2'(e_f)) begin
                failures++;
                $display("FAIL %s model: got v=%0d pa=%0d f=%0d exp v=%0d pa=%0d f=%0d",
                         tag, rsp_valid, rsp_paddr, rsp_fault, e_v, e_pa, e_f);
            end
        end
    end

    task automatic expect_rsp(string tag, int pa, int f);
        checks++;
        if (rsp_valid !== 1'b1 || rsp_paddr !== (BASE_W+1)'(pa) || rsp_fault !== 2'(f)) begin
            failures++;
            $display("FAIL %s: got v=%0d pa=%0d f=%0d exp v=1 pa=%0d f=%0d",
                     tag, rsp_valid, rsp_paddr, rsp_fault, pa, f);
        end
    endtask

    task automatic wr(int idx, int base, int lim, bit pres, int perm);
        @(negedge clk);
        wr_en = 1; wr_idx = SEG_W'(idx); wr_base = BASE_W'(base);
        wr_limit = (OFF_W+1)'(lim); wr_present = pres; wr_perm = 3'(perm);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic look(string tag, int seg, int off, int acc, int pa, int f);
        @(negedge clk);
        req_valid = 1; req_seg = SEG_W'(seg); req_off = OFF_W'(off); req_acc = 2'(acc);
        @(negedge clk);
        expect_rsp(tag, pa, f);
        req_valid = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (rsp_valid !== 0 || rsp_paddr !== 0 || rsp_fault !== 0) begin
            failures++;
            $display("FAIL R1: got v=%0d pa=%0d f=%0d exp 0 0 0", rsp_valid, rsp_paddr, rsp_fault);
        end
        rst_n = 1;
        look("R1", 0, 0, 0, 0, 1);

        wr(0, 1400, 1000, 1, 3'b101);   // code: read+exec
        wr(1, 6300, 400, 1, 3'b011);    // data: read+write
        wr(2, 4700, 1100, 1, 3'b011);
        look("R3", 0, 430, 0, 1830, 0);
        look("R3", 1, 10, 1, 6310, 0);
        look("R3", 0, 999, 2, 2399, 0);     // limit-1 boundary
        look("R4", 0, 1000, 0, 0, 2);       // offset equal to limit
        look("R4", 0, 1500, 0, 0, 2);
        look("R6", 0, 5, 1, 0, 3);          // write to code
        look("R6", 1, 5, 2, 0, 3);          // exec data
        look("R6", 1, 5, 3, 0, 3);          // reserved kind
        look("R5", 3, 100, 0, 0, 1);        // never loaded
        look("R5", 12, 0, 0, 0, 1);         // beyond table
        // R7: out-of-limit plus bad permission -> limit wins
        look("R7", 0, 2000, 1, 0, 2);
        // R7: absent plus out-of-limit -> absent wins
        wr(4, 100, 10, 0, 3'b111);
        look("R7", 4, 50, 3, 0, 1);
        // R8: faults carry zero address
        look("R8", 2, 1100, 0, 0, 2);
        // R11: shared region
        wr(5, 1400, 1000, 1, 3'b101);
        look("R11", 5, 430, 0, 1830, 0);
        // R10: stray write leaves entries intact
        wr(9, 7, 7, 1, 3'b111);
        look("R10", 0, 430, 0, 1830, 0);
        look("R10", 1, 10, 0, 6310, 0);
        // R9: same-edge lookup sees old entry, next sees new
        @(negedge clk);
        wr_en = 1; wr_idx = 6; wr_base = 16'd9000; wr_limit = 13'd50; wr_present = 1; wr_perm = 3'b001;
        req_valid = 1; req_seg = 6; req_off = 5; req_acc = 0;
        @(negedge clk);
        expect_rsp("R9", 0, 1);
        wr_en = 0;
        @(negedge clk);
        expect_rsp("R9", 9005, 0);
        req_valid = 0;
        // Random traffic checked by the model every cycle (R2..R6)
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            wr_en = ($urandom_range(0, 5) == 0);
            wr_idx = SEG_W'($urandom_range(0, 9));
            wr_base = BASE_W'($urandom);
            wr_limit = (OFF_W+1)'($urandom_range(0, 4096));
            wr_present = ($urandom_range(0, 4) != 0);
            wr_perm = 3'($urandom);
            req_valid = ($urandom_range(0, 3) != 0);
            req_seg = SEG_W'($urandom_range(0, 9));
            req_off = OFF_W'($urandom);
            req_acc = 2'($urandom);
        end
        @(negedge clk);
        wr_en = 0; req_valid = 0;
        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule